// File: doc/BRIEF.md
# Signed-Count Bidirectional Word Shifter

This block is a registered logical shifter for a 16-bit datapath. A request carries an operation code, a data word and a signed two's-complement count. The shifter computes the result in one cycle and registers it, with a single-cycle `done` pulse. In variable mode the count's sign picks the direction. A negative count turns a left shift into a right shift, and a right shift into a left shift, by the count's magnitude. Any magnitude of 16 or more gives an all-zero word rather than a wrapped amount.

A fixed mode shifts by a small constant held in the operation code itself, and the count operand is ignored. Left shifts take 1 to 7 positions and right shifts take 1 to 6. The remaining fixed encodings are rejected: no result is produced and the output register keeps its contents. All shifts fill vacated bit positions with zeros.

Top module: `word_shifter`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `done` is 0.
- R2: Variable mode (`op[4]`=0) with `op[3]`=0 (left) and a count c in 0..15 gives `data << c`.
- R3: Variable mode with `op[3]`=1 (right) and a count c in 0..15 gives `data >> c`.
- R4: In variable mode a negative count c in -15..-1 reverses the direction. A left operation gives `data >> -c` and a right operation gives `data << -c`.
- R5: In variable mode an effective magnitude of 16 or more gives 0 in either direction. This includes count 0x8000, which is taken as magnitude 32768.
- R6: In variable mode a count of 0 returns `data` unchanged for both directions.
- R7: Fixed mode (`op[4]`=1) shifts by the amount in `op[2:0]` and ignores `count`. Left (`op[3]`=0) accepts amounts 1..7 and right (`op[3]`=1) accepts amounts 1..6.
- R8: A fixed request with amount 0, or a fixed right request with amount 7, is rejected. `done` stays low and `result` keeps its previous value.
- R9: An accepted request updates `result` on the first clock edge after `in_valid` is sampled high, and `done` is high for exactly that one cycle. With `in_valid` low, `done` is low and `result` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, sampled on the rising edge |
| op | input | 5 | [4] fixed mode, [3] direction (1 = right), [2:0] fixed amount |
| data | input | 16 | Word to shift |
| count | input | 16 | Signed shift count (variable mode only) |
| result | output | 16 | Registered shift result |
| done | output | 1 | One-cycle pulse when `result` has just been updated |

## Verification
The embedded assertions check the following on every cycle:
- the done handshake and the holding of `result` when idle or on a rejected fixed code;
- the forced-zero result for out-of-range signed counts;
- pass-through on a zero count.

Only the bench's scenarios can show the exact bit patterns of the shifts, because those need a reference model. These include:
- direction reversal at counts such as -15 and 15;
- the -16/16 boundaries and 0x8000;
- every legal fixed amount.

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int W  = 16,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [FW+1:0] op,
  input  logic [W-1:0]  data,
  input  logic [W-1:0]  count,
  output logic [W-1:0]  result,
  output logic          done
);
  localparam int SW = $clog2(W);
  localparam logic [W:0] LIMIT = (W+1)'(W);

  logic          fixed_mode, dir_right, neg, big, legal, go_right;
  logic [FW-1:0] fix_amt;
  logic [W:0]    mag;
  logic [SW-1:0] amt;
  logic [W-1:0]  shifted, next_val;

  assign fixed_mode = op[FW+1];
  assign dir_right  = op[FW];
  assign fix_amt    = op[FW-1:0];

  assign neg = count[W-1];
  assign mag = neg ? ({1'b0, ~count} + 1'b1) : {1'b0, count};
  assign big = !fixed_mode && (mag >= LIMIT);

  assign go_right = fixed_mode ? dir_right : (dir_right ^ neg);
  assign amt      = fixed_mode ? SW'(fix_amt) : mag[SW-1:0];

  assign legal = !fixed_mode ||
                 ((fix_amt != '0) && !(dir_right && (fix_amt == '1)));

  assign shifted  = go_right ? (data >> amt) : (data << amt);
  assign next_val = big ? '0 : shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= in_valid && legal;
      if (in_valid && legal)
        result <= next_val;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && !done)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && $stable(result))); // R9

  AST_VAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[FW+1]) |=> done); // R9

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[FW+1] && (op[FW-1:0] == '0 || (op[FW] && op[FW-1:0] == '1)))
      |=> (!done && $stable(result))); // R8

  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[FW+1] && ($signed(count) >= W || $signed(count) <= -W))
      |=> (result == '0)); // R5

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[FW+1] && count == '0) |=> (result == $past(data))); // R6
endmodule

// File: tb/sim_word_shifter.sv
module sim_word_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] data = '0;
  logic [15:0] count = '0;
  logic [15:0] result;
  logic        done;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] last_res = '0;

  always #5 clk = ~clk;

  word_shifter u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
                   .data(data), .count(count), .result(result), .done(done));

  function automatic logic [16:0] model(input logic [4:0] o, input logic [15:0] d,
                                        input logic [15:0] c);
    int a, eff;
    if (o[4]) begin
      a = int'(o[2:0]);
      if (a == 0 || (o[3] && a == 7)) return {1'b0, 16'h0};
      return {1'b1, o[3] ? (d >> a) : (d << a)};
    end
    eff = int'($signed(c));
    if (o[3]) eff = -eff;
    if (eff >= 16 || eff <= -16) return {1'b1, 16'h0};
    if (eff >= 0) return {1'b1, d << eff};
    return {1'b1, d >> (-eff)};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] o, input logic [15:0] c);
    int s;
    s = int'($signed(c));
    if (o[4]) return (o[2:0] == 0 || (o[3] && o[2:0] == 7)) ? "R8" : "R7";
    if (s == 0) return "R6";
    if (s >= 16 || s <= -16) return "R5";
    if (s < 0) return "R4";
    return o[3] ? "R3" : "R2";
  endfunction

  task automatic apply(input logic [4:0] o, input logic [15:0] d, input logic [15:0] c);
    logic [16:0] m;
    string t;
    m = model(o, d, c);
    t = tag_of(o, c);
    op = o; data = d; count = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (m[16]) last_res = m[15:0];
    check(t, result, last_res);
    check(m[16] ? "R9" : "R8", {15'b0, done}, {15'b0, m[16]});
    @(negedge clk);
    check("R9", {15'b0, done}, 16'h0);
    check("R9", result, last_res);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    check("R1", result, 16'h0);
    check("R1", {15'b0, done}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    apply(5'b00000, 16'hA5C3, 16'd0);
    apply(5'b01000, 16'hA5C3, 16'd0);
    apply(5'b00000, 16'h8001, 16'd15);
    apply(5'b01000, 16'h8001, 16'd15);
    apply(5'b00000, 16'hFFFF, 16'd16);
    apply(5'b01000, 16'hFFFF, 16'd16);
    apply(5'b00000, 16'hFFFF, 16'hFFF1);
    apply(5'b01000, 16'hFFFF, 16'hFFF1);
    apply(5'b00000, 16'hFFFF, 16'hFFF0);
    apply(5'b01000, 16'hFFFF, 16'hFFF0);
    apply(5'b00000, 16'hFFFF, 16'h8000);
    apply(5'b01000, 16'hFFFF, 16'h8000);
    apply(5'b00000, 16'h1234, 16'h7FFF);
    apply(5'b00000, 16'h1234, 16'd4);
    apply(5'b01000, 16'h1234, 16'hFFFC);
    for (int a = 0; a < 8; a++) begin
      apply({2'b10, 3'(a)}, 16'hF00F, 16'h0);
      apply({2'b11, 3'(a)}, 16'hF00F, 16'h5);
    end
    for (int i = 0; i < 400; i++) begin
      logic [4:0]  o;
      logic [15:0] c;
      o = 5'($urandom);
      if (i % 2 == 0) c = 16'($signed(int'($urandom_range(0, 40)) - 20));
      else c = 16'($urandom);
      apply(o, 16'($urandom), c);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule